// File: doc/BRIEF.md
# System-Management and Suspend Mode Sequencer

This block is the control state machine that follows a processor core through its system-management episodes. A management interrupt request in normal operation starts a header save. Once the save handshake returns, the sequencer gives a single-cycle pulse that returns the control, flag and debug registers to their power-up values. It then parks in the service-routine state, where execution begins at the management base address in real mode. A resume strobe ends the episode. It raises a header-restore request, and after the restore handshake completes it drops back to normal operation.

Inside the service routine the core can be put to sleep in two ways: a HALT strobe, or the external suspend pin. A wake event brings it back to the service routine, and so does releasing the pin when the pin caused the sleep. It never goes straight back to normal mode. While the management mode is active, maskable interrupts are blocked, because the flags were cleared on entry. The non-maskable request always passes.

Top module: `smm_mode_seq`

## Requirements
- R1: After reset, mode_state is 0 (normal), smm_active is 0, int_mask is 2'b11, and reg_reset_pulse, restore_req and suspend_ack are 0.
- R2: In normal mode, smi_req moves mode_state to 1 (header save). It stays at 1 until save_done is seen. The next state is 2 (clear) for exactly one cycle, with reg_reset_pulse high, and then 3 (service routine).
- R3: int_mask bit 0 (maskable enable) is 0 whenever smm_active is 1, and 1 otherwise. int_mask bit 1 (non-maskable enable) is always 1. intr_fwd equals intr_req AND int_mask[0], and nmi_fwd equals nmi_req.
- R4: smm_active is 1 in mode_state 1 through 5 and 0 in mode_state 0.
- R5: In state 3, rsm_stb moves mode_state to 5 (restore) with restore_req high. rsm_stb wins over halt_stb and susp_in in the same cycle.
- R6: State 5 holds until restore_done is seen, then mode_state returns to 0.
- R7: In state 3, without rsm_stb, halt_stb or susp_in moves mode_state to 4 (suspend), and suspend_ack is high in that state.
- R8: State 4 returns to 3 on wake_evt. If susp_in was high on the entry cycle, it also returns to 3 when susp_in is low. If entry was by HALT alone, a low susp_in has no effect.
- R9: smi_req has no effect in any state other than 0.
- R10: In state 0, rsm_stb, halt_stb, susp_in, wake_evt and restore_done have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smi_req | input | 1 | Management interrupt request |
| save_done | input | 1 | Header save complete |
| rsm_stb | input | 1 | Resume instruction strobe |
| halt_stb | input | 1 | HALT instruction strobe |
| susp_in | input | 1 | External suspend pin |
| wake_evt | input | 1 | Wake event from suspend |
| restore_done | input | 1 | Header restore complete |
| intr_req | input | 1 | Maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| mode_state | output | 3 | Current mode (0..5, see requirements) |
| smm_active | output | 1 | Management mode active |
| reg_reset_pulse | output | 1 | One-cycle register reset pulse |
| restore_req | output | 1 | Header restore request |
| int_mask | output | 2 | Bit 1 non-maskable enable, bit 0 maskable enable |
| intr_fwd | output | 1 | Maskable request after masking |
| nmi_fwd | output | 1 | Non-maskable request forwarded |
| suspend_ack | output | 1 | Suspend acknowledge |

## Verification
The assertions assume only that every input is synchronous to clk and has a known value from the first clock after reset. Strobes are not assumed to be single-cycle, and handshakes are not assumed to come only when expected. The random stimulus draws every input on every cycle, with the rates set so that resume and sleep strobes stay sparse. That lets the save, service-routine and suspend states be reached often, while stray handshakes and strobes still land in states that must ignore them.

// File: rtl/smm_seq_pkg.sv
package smm_seq_pkg;

  localparam int MODE_W = 3;
  localparam int IRQ_W  = 2;

  typedef enum logic [MODE_W-1:0] {
    MS_NORMAL  = 3'd0,
    MS_SAVE    = 3'd1,
    MS_CLEAR   = 3'd2,
    MS_ROUTINE = 3'd3,
    MS_SUSPEND = 3'd4,
    MS_RESTORE = 3'd5
  } mode_e;

  // management mode spans every state except normal
  function automatic logic in_smm(input mode_e m);
    return (m != MS_NORMAL);
  endfunction

  // leave suspend: wake always, pin release only when pin caused entry
  function automatic logic susp_leave(input logic wake, input logic susp,
                                      input logic by_pin);
    return wake | (by_pin & ~susp);
  endfunction

  // sleep request from inside the routine
  function automatic logic susp_enter(input logic halt, input logic susp);
    return halt | susp;
  endfunction

  function automatic mode_e next_mode(input mode_e cur, input logic smi,
                                      input logic sdone, input logic rsm,
                                      input logic halt, input logic susp,
                                      input logic wake, input logic by_pin,
                                      input logic rdone);
    mode_e n;
    n = cur;
    case (cur)
      MS_NORMAL:  if (smi) n = MS_SAVE;
      MS_SAVE:    if (sdone) n = MS_CLEAR;
      MS_CLEAR:   n = MS_ROUTINE;
      MS_ROUTINE: begin
        if (rsm) n = MS_RESTORE;
        else if (susp_enter(halt, susp)) n = MS_SUSPEND;
      end
      MS_SUSPEND: if (susp_leave(wake, susp, by_pin)) n = MS_ROUTINE;
      MS_RESTORE: if (rdone) n = MS_NORMAL;
      default:    n = MS_NORMAL;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/smm_seq_fsm.sv
module smm_seq_fsm
  import smm_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  smi_req,
  input  logic  save_done,
  input  logic  rsm_stb,
  input  logic  halt_stb,
  input  logic  susp_in,
  input  logic  wake_evt,
  input  logic  restore_done,
  input  logic  by_pin,
  output mode_e state,
  output logic  enter_susp
);

  mode_e nxt;

  always_comb begin
    nxt = next_mode(state, smi_req, save_done, rsm_stb, halt_stb, susp_in,
                    wake_evt, by_pin, restore_done);
  end

  assign enter_susp = (state == MS_ROUTINE) && (nxt == MS_SUSPEND);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= MS_NORMAL;
    else        state <= nxt;
  end

  AST_SAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_SAVE && !save_done) |=> (state == MS_SAVE)); // R2
  AST_CLEAR_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_CLEAR) |=> (state == MS_ROUTINE)); // R2
  AST_RSM_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_ROUTINE && rsm_stb) |=> (state == MS_RESTORE)); // R5
  AST_RESTORE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_RESTORE && !restore_done) |=> (state == MS_RESTORE)); // R6
  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_ROUTINE && !rsm_stb && (halt_stb || susp_in)) |=> (state == MS_SUSPEND)); // R7
  AST_WAKE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_SUSPEND) |=> (state == MS_SUSPEND || state == MS_ROUTINE)); // R8
  AST_SMI_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state != MS_NORMAL && state != MS_SAVE) |=> (state != MS_SAVE)); // R9
  AST_NORMAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == MS_NORMAL && !smi_req) |=> (state == MS_NORMAL)); // R10

endmodule

// File: rtl/smm_susp_cause.sv
module smm_susp_cause (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_susp,
  input  logic susp_in,
  output logic by_pin
);

  always_ff @(posedge clk) begin
    if (!rst_n)          by_pin <= 1'b0;
    else if (enter_susp) by_pin <= susp_in;
  end

  AST_CAUSE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    enter_susp |=> (by_pin == $past(susp_in))); // R8

endmodule

// File: rtl/smm_irq_gate.sv
module smm_irq_gate
  import smm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smm_active,
  input  logic             intr_req,
  input  logic             nmi_req,
  output logic [IRQ_W-1:0] int_mask,
  output logic             intr_fwd,
  output logic             nmi_fwd
);

  localparam int INTR_BIT = 0;
  localparam int NMI_BIT  = IRQ_W - 1;

  logic [IRQ_W-1:0] req_vec;
  logic [IRQ_W-1:0] fwd_vec;

  assign req_vec[INTR_BIT] = intr_req;
  assign req_vec[NMI_BIT]  = nmi_req;

  assign int_mask[INTR_BIT] = ~smm_active;
  assign int_mask[NMI_BIT]  = 1'b1;

  for (genvar g = 0; g < IRQ_W; g++) begin : g_gate
    assign fwd_vec[g] = req_vec[g] & int_mask[g];
  end

  assign intr_fwd = fwd_vec[INTR_BIT];
  assign nmi_fwd  = fwd_vec[NMI_BIT];

  AST_INTR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    smm_active |-> !intr_fwd); // R3
  AST_NMI_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> nmi_fwd); // R3

endmodule

// File: rtl/smm_mode_seq.sv
module smm_mode_seq
  import smm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smi_req,
  input  logic             save_done,
  input  logic             rsm_stb,
  input  logic             halt_stb,
  input  logic             susp_in,
  input  logic             wake_evt,
  input  logic             restore_done,
  input  logic             intr_req,
  input  logic             nmi_req,
  output logic [MODE_W-1:0] mode_state,
  output logic             smm_active,
  output logic             reg_reset_pulse,
  output logic             restore_req,
  output logic [IRQ_W-1:0] int_mask,
  output logic             intr_fwd,
  output logic             nmi_fwd,
  output logic             suspend_ack
);

  mode_e state;
  logic  enter_susp;
  logic  by_pin;

  smm_seq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .smi_req      (smi_req),
    .save_done    (save_done),
    .rsm_stb      (rsm_stb),
    .halt_stb     (halt_stb),
    .susp_in      (susp_in),
    .wake_evt     (wake_evt),
    .restore_done (restore_done),
    .by_pin       (by_pin),
    .state        (state),
    .enter_susp   (enter_susp)
  );

  smm_susp_cause u_cause (
    .clk        (clk),
    .rst_n      (rst_n),
    .enter_susp (enter_susp),
    .susp_in    (susp_in),
    .by_pin     (by_pin)
  );

  assign mode_state      = state;
  assign smm_active      = in_smm(state);
  assign reg_reset_pulse = (state == MS_CLEAR);
  assign restore_req     = (state == MS_RESTORE);
  assign suspend_ack     = (state == MS_SUSPEND);

  smm_irq_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .smm_active (smm_active),
    .intr_req   (intr_req),
    .nmi_req    (nmi_req),
    .int_mask   (int_mask),
    .intr_fwd   (intr_fwd),
    .nmi_fwd    (nmi_fwd)
  );

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset_pulse |=> !reg_reset_pulse); // R2
  AST_ACTIVE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smm_active) |-> (mode_state == 3'd1)); // R4
  AST_ACTIVE_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smm_active) |-> ($past(restore_req) && $past(restore_done))); // R4

endmodule

// File: tb/sim_smm_mode_seq.sv
module sim_smm_mode_seq;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smi_req = 0, save_done = 0, rsm_stb = 0, halt_stb = 0, susp_in = 0;
  logic wake_evt = 0, restore_done = 0, intr_req = 0, nmi_req = 0;
  logic [2:0] mode_state;
  logic smm_active, reg_reset_pulse, restore_req, intr_fwd, nmi_fwd, suspend_ack;
  logic [1:0] int_mask;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int m_state = 0;
  bit m_pin = 0;

  always #5 clk = ~clk;

  smm_mode_seq u0 (
    .clk(clk), .rst_n(rst_n), .smi_req(smi_req), .save_done(save_done),
    .rsm_stb(rsm_stb), .halt_stb(halt_stb), .susp_in(susp_in),
    .wake_evt(wake_evt), .restore_done(restore_done), .intr_req(intr_req),
    .nmi_req(nmi_req), .mode_state(mode_state), .smm_active(smm_active),
    .reg_reset_pulse(reg_reset_pulse), .restore_req(restore_req),
    .int_mask(int_mask), .intr_fwd(intr_fwd), .nmi_fwd(nmi_fwd),
    .suspend_ack(suspend_ack)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      bad++; total++;
      $display("FAIL watchdog: act=%0d exp=<200000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // model of the next state, written from the requirements
  function automatic int model_next(int s, bit pin);
    if (s == 0) return smi_req ? 1 : 0;                          // R2 R10
    if (s == 1) return save_done ? 2 : 1;                        // R2 R9
    if (s == 2) return 3;                                        // R2
    if (s == 3) begin
      if (rsm_stb) return 5;                                     // R5
      if (halt_stb || susp_in) return 4;                         // R7
      return 3;
    end
    if (s == 4) return (wake_evt || (pin && !susp_in)) ? 3 : 4;  // R8
    return restore_done ? 0 : 5;                                 // R6
  endfunction

  task automatic check_outs(input string mtag);
    bit act_smm;
    act_smm = (m_state != 0);
    chk(mode_state == m_state[2:0], mtag, mode_state, m_state);
    chk(smm_active == act_smm, "R4", smm_active, act_smm);
    chk(reg_reset_pulse == (m_state == 2), "R2", reg_reset_pulse, m_state == 2);
    chk(restore_req == (m_state == 5), "R5", restore_req, m_state == 5);
    chk(suspend_ack == (m_state == 4), "R7", suspend_ack, m_state == 4);
    chk(int_mask == {1'b1, !act_smm}, "R3", int_mask, {1'b1, !act_smm});
    chk(intr_fwd == (intr_req && !act_smm), "R3", intr_fwd, intr_req && !act_smm);
    chk(nmi_fwd == nmi_req, "R3", nmi_fwd, nmi_req);
  endtask

  // inputs already set at a negedge; advance one clock and compare
  task automatic step(input string mtag);
    int n;
    n = model_next(m_state, m_pin);
    if (m_state == 3 && n == 4) m_pin = susp_in;
    @(posedge clk);
    @(negedge clk);
    m_state = n;
    check_outs(mtag);
  endtask

  task automatic drive(input bit smi, sd, rsm, halt, susp, wake, rd);
    smi_req = smi; save_done = sd; rsm_stb = rsm; halt_stb = halt;
    susp_in = susp; wake_evt = wake; restore_done = rd;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_state = 0; m_pin = 0;
    check_outs("R1");
    chk(int_mask == 2'b11, "R1", int_mask, 3);

    // R10: resume, halt, pin, wake and restore handshake ignored in normal mode
    drive(0, 1, 1, 1, 1, 1, 1); step("R10");
    drive(0, 1, 1, 1, 1, 1, 1); step("R10");
    intr_req = 1; nmi_req = 1;
    drive(1, 0, 0, 0, 0, 0, 0); step("R2");       // to save
    drive(1, 0, 0, 0, 0, 0, 0); step("R9");       // smi during save
    drive(0, 0, 0, 0, 0, 0, 0); step("R2");
    drive(0, 1, 0, 0, 0, 0, 0); step("R2");       // clear pulse
    drive(1, 0, 0, 0, 0, 0, 0); step("R2");       // routine, smi ignored
    drive(1, 0, 0, 0, 0, 0, 0); step("R9");
    drive(0, 0, 0, 1, 0, 0, 0); step("R7");       // halt -> suspend
    drive(1, 0, 0, 0, 0, 0, 0); step("R8");       // pin low, halt entry: stay
    drive(0, 0, 0, 0, 0, 1, 0); step("R8");       // wake -> routine
    drive(0, 0, 0, 0, 1, 0, 0); step("R7");       // pin -> suspend
    drive(0, 0, 0, 0, 1, 0, 0); step("R8");       // pin still high
    drive(0, 0, 0, 0, 0, 0, 0); step("R8");       // pin release -> routine
    drive(0, 0, 1, 1, 1, 0, 0); step("R5");       // resume beats sleep
    drive(1, 0, 0, 0, 0, 0, 0); step("R6");       // wait restore
    drive(0, 0, 0, 0, 0, 0, 1); step("R6");       // back to normal
    drive(0, 0, 0, 0, 0, 0, 0); step("R3");

    for (int i = 0; i < 4000; i++) begin
      bit r_smi, r_sd, r_rsm, r_halt, r_susp, r_wake, r_rd;
      r_smi  = ($urandom % 4) == 0;
      r_sd   = ($urandom % 3) == 0;
      r_rsm  = ($urandom % 10) == 0;
      r_halt = ($urandom % 8) == 0;
      r_susp = ($urandom % 6) == 0;
      r_wake = ($urandom % 5) == 0;
      r_rd   = ($urandom % 3) == 0;
      intr_req = $urandom % 2;
      nmi_req  = $urandom % 2;
      drive(r_smi, r_sd, r_rsm, r_halt, r_susp, r_wake, r_rd);
      step("R2");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule